// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block produces the power-up and refresh commands for an SDRAM hanging off an external memory bus. When the chip-select slot is switched into SDRAM mode, the block runs a fixed power-up sequence: a precharge of all banks, two auto-refresh commands, and a load-mode-register command. A programmable number of idle cycles follows each command. Nothing can break into this sequence. Bus accesses are held off until it is complete, and the mode-register value is latched at the moment the sequence starts.

Once the SDRAM is ready, a refresh timer produces a request every programmed period. A request that cannot be served at once, because the bus is busy on another chip select or partway through a transfer, goes into a backlog of up to four entries. The backlog drains as soon as the bus is free, and refresh wins over a waiting read or write. An expiry that arrives while the backlog is full is dropped, and a sticky flag records it. When the interface runs at twice the core clock, the block drives the SDRAM clock-enable.

Top module: `sdram_seq_top`

## Requirements
- R1: During reset, the command output is NOP (code 0), and init_done, acc_grant, ref_pending, ref_overflow and cke are all zero.
- R2: If sdram_mode_en is sampled high at a clock edge while the sequencer is idle, a precharge-all command (code 1) appears in the cycle after that edge.
- R3: Initialization issues precharge-all, auto-refresh (code 2), auto-refresh, then load-mode (code 3), with exactly cmd_wait NOP cycles after each. init_done rises cmd_wait+1 cycles after the load-mode cycle.
- R4: During the load-mode cycle, sdram_mode_word carries the mode_word value sampled when initialization started. Later changes to mode_word have no effect.
- R5: acc_grant stays low throughout initialization, whatever acc_req is. Dropping sdram_mode_en during initialization does not stop or change the sequence.
- R6: With refresh_period P nonzero and init_done high, the timer expires every P cycles. The first expiry comes P edges after the first edge at which both conditions hold. On a free bus, auto-refresh appears in the cycle after the edge that follows the expiry.
- R7: While refresh_period is zero, the timer does not run and no refresh is issued.
- R8: Expiries that occur while bus_busy is high raise ref_pending, which saturates at 4. An expiry that arrives while the count is 4 is dropped and sets ref_overflow, which stays set until the next initialization starts.
- R9: Once bus_busy falls, pending refreshes are issued starting at the first free edge, with cmd_wait NOP cycles between them. Each one lowers ref_pending by one, and acc_grant stays low while ref_pending is nonzero.
- R10: acc_grant is high only when init_done, acc_req and a free bus all hold, with no refresh pending and the post-refresh gap elapsed.
- R11: cke goes high one cycle after clk2x_mode is sampled high while the mode is enabled or the sequencer is not idle. It falls one cycle after clk2x_mode is sampled low.
- R12: Dropping sdram_mode_en after init_done returns the sequencer to idle (init_done low on the next cycle) and stops refresh. Raising it again reruns the full initialization and clears ref_overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sdram_mode_en | input | 1 | Chip-select slot set to SDRAM mode |
| clk2x_mode | input | 1 | Interface clocked at twice the core clock |
| cmd_wait | input | WAIT_W | Idle cycles after each issued command |
| refresh_period | input | PER_W | Refresh interval in cycles, 0 stops the timer |
| mode_word | input | MR_W | Mode-register value to load |
| bus_busy | input | 1 | Bus occupied by another chip select or a transfer |
| acc_req | input | 1 | Read or write access wants the SDRAM |
| acc_grant | output | 1 | Access may proceed this cycle |
| sdram_cmd | output | 2 | 0 NOP, 1 precharge-all, 2 auto-refresh, 3 load-mode |
| sdram_mode_word | output | MR_W | Value presented with load-mode |
| cke | output | 1 | SDRAM clock enable |
| init_done | output | 1 | Initialization complete |
| ref_pending | output | PEND_W | Refreshes waiting to be issued |
| ref_overflow | output | 1 | A refresh expiry was dropped |

## Verification
Every command is registered, so it appears in the cycle after the edge that sampled its cause. Initialization commands come exactly cmd_wait+1 cycles apart. A refresh appears two edges after its timer expiry when the bus is free, or one edge after bus_busy falls when it is backlogged. acc_grant is combinational and is checked one time step after the inputs change. The driver computes the exact cycle of every command from these rules and queues it. The monitor samples on the falling edge, and any command that is early, late, of the wrong kind or not expected at all is reported.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

   typedef enum logic [1:0] {
      CMD_NOP    = 2'd0,
      CMD_PREALL = 2'd1,
      CMD_AREF   = 2'd2,
      CMD_LMR    = 2'd3
   } sdcmd_e;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_INIT,
      SQ_READY
   } seq_st_e;

   localparam int INIT_STEPS = 4;

   function automatic sdcmd_e init_step_cmd(input logic [1:0] idx);
      case (idx)
         2'd0:    return CMD_PREALL;
         2'd3:    return CMD_LMR;
         default: return CMD_AREF;
      endcase
   endfunction

endpackage

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
   import sdram_seq_pkg::*;
#(
   parameter int WAIT_W = 4,
   parameter int MR_W   = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_en,
   input  logic [WAIT_W-1:0] wait_cycles,
   input  logic [MR_W-1:0]   mode_word,
   output logic              init_fire,
   output sdcmd_e            init_cmd,
   output logic              init_start,
   output logic              init_active,
   output logic              init_done,
   output logic [MR_W-1:0]   mr_q
);

   localparam logic [1:0] LAST_STEP = 2'(INIT_STEPS - 1);

   seq_st_e           st_q;
   logic [1:0]        step_q;
   logic [WAIT_W-1:0] cnt_q;
   logic              last_step;
   logic              step_adv;

   assign last_step   = (step_q == LAST_STEP);
   assign init_start  = (st_q == SQ_IDLE) && mode_en;
   assign step_adv    = (st_q == SQ_INIT) && (cnt_q == '0) && !last_step;
   assign init_fire   = init_start || step_adv;
   assign init_cmd    = init_step_cmd(init_start ? 2'd0 : 2'(step_q + 2'd1));
   assign init_active = (st_q == SQ_INIT);
   assign init_done   = (st_q == SQ_READY);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         step_q <= '0;
         cnt_q  <= '0;
         mr_q   <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: if (mode_en) begin
               st_q   <= SQ_INIT;
               step_q <= '0;
               cnt_q  <= wait_cycles;
               mr_q   <= mode_word;
            end
            SQ_INIT: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - WAIT_W'(1);
               end else if (last_step) begin
                  st_q <= SQ_READY;
               end else begin
                  step_q <= 2'(step_q + 2'd1);
                  cnt_q  <= wait_cycles;
               end
            end
            SQ_READY: if (!mode_en) st_q <= SQ_IDLE;
            default:  st_q <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PER_W-1:0] period,
   output logic             expire
);

   logic [PER_W-1:0] tmr_q;
   logic             active;

   assign active = run && (period != '0);
   assign expire = active && (tmr_q >= period - PER_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n || !active || expire) tmr_q <= '0;
      else                             tmr_q <= tmr_q + PER_W'(1);
   end

endmodule

// File: rtl/sdram_ref_backlog.sv
module sdram_ref_backlog #(
   parameter int REF_MAX = 4,
   parameter int PEND_W  = 3,
   parameter int WAIT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              clear_ovf,
   input  logic              expire,
   input  logic              bus_busy,
   input  logic [WAIT_W-1:0] wait_cycles,
   output logic              ref_fire,
   output logic              gap_idle,
   output logic [PEND_W-1:0] pend_q,
   output logic              ovf_q
);

   localparam logic [PEND_W-1:0] PEND_CAP = PEND_W'(REF_MAX);

   logic [WAIT_W-1:0] gap_q;

   assign gap_idle = (gap_q == '0);
   assign ref_fire = enable && (pend_q != '0) && !bus_busy && gap_idle;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= '0;
         gap_q  <= '0;
         ovf_q  <= 1'b0;
      end else begin
         if (clear_ovf) ovf_q <= 1'b0;
         if (!enable) begin
            pend_q <= '0;
            gap_q  <= '0;
         end else begin
            case ({expire, ref_fire})
               2'b10: begin
                  if (pend_q == PEND_CAP) ovf_q  <= 1'b1;
                  else                    pend_q <= pend_q + PEND_W'(1);
               end
               2'b01:   pend_q <= pend_q - PEND_W'(1);
               default: pend_q <= pend_q;
            endcase
            if (ref_fire)            gap_q <= wait_cycles;
            else if (gap_q != '0)    gap_q <= gap_q - WAIT_W'(1);
         end
      end
   end

endmodule

// File: rtl/sdram_seq_top.sv
module sdram_seq_top
   import sdram_seq_pkg::*;
#(
   parameter int MR_W    = 13,
   parameter int PER_W   = 16,
   parameter int WAIT_W  = 4,
   parameter int REF_MAX = 4,
   parameter bit HAS_CKE = 1'b1,
   localparam int PEND_W = $clog2(REF_MAX + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sdram_mode_en,
   input  logic              clk2x_mode,
   input  logic [WAIT_W-1:0] cmd_wait,
   input  logic [PER_W-1:0]  refresh_period,
   input  logic [MR_W-1:0]   mode_word,
   input  logic              bus_busy,
   input  logic              acc_req,
   output logic              acc_grant,
   output logic [1:0]        sdram_cmd,
   output logic [MR_W-1:0]   sdram_mode_word,
   output logic              cke,
   output logic              init_done,
   output logic [PEND_W-1:0] ref_pending,
   output logic              ref_overflow
);

   if (REF_MAX < 1 || REF_MAX > 15) begin : g_bad_refmax
      $error("REF_MAX must lie in 1..15");
   end
   if (WAIT_W < 1 || PER_W < 2 || MR_W < 1) begin : g_bad_width
      $error("WAIT_W, PER_W and MR_W are too narrow");
   end

   logic   init_fire, init_start, init_active;
   sdcmd_e init_cmd;
   logic   expire, ref_fire, gap_idle;
   sdcmd_e cmd_q;

   sdram_init_fsm #(.WAIT_W(WAIT_W), .MR_W(MR_W)) u_init (
      .clk(clk), .rst_n(rst_n), .mode_en(sdram_mode_en),
      .wait_cycles(cmd_wait), .mode_word(mode_word),
      .init_fire(init_fire), .init_cmd(init_cmd), .init_start(init_start),
      .init_active(init_active), .init_done(init_done), .mr_q(sdram_mode_word)
   );

   sdram_ref_timer #(.PER_W(PER_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .run(init_done),
      .period(refresh_period), .expire(expire)
   );

   sdram_ref_backlog #(.REF_MAX(REF_MAX), .PEND_W(PEND_W), .WAIT_W(WAIT_W)) u_blog (
      .clk(clk), .rst_n(rst_n), .enable(init_done), .clear_ovf(init_start),
      .expire(expire), .bus_busy(bus_busy), .wait_cycles(cmd_wait),
      .ref_fire(ref_fire), .gap_idle(gap_idle),
      .pend_q(ref_pending), .ovf_q(ref_overflow)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)         cmd_q <= CMD_NOP;
      else if (init_fire) cmd_q <= init_cmd;
      else if (ref_fire)  cmd_q <= CMD_AREF;
      else                cmd_q <= CMD_NOP;
   end

   assign sdram_cmd = cmd_q;
   assign acc_grant = init_done && acc_req && !bus_busy &&
                      (ref_pending == '0) && gap_idle;

   if (HAS_CKE) begin : g_cke_drv
      logic cke_q;
      always_ff @(posedge clk) begin
         if (!rst_n) cke_q <= 1'b0;
         else        cke_q <= clk2x_mode && (sdram_mode_en || init_active || init_done);
      end
      assign cke = cke_q;
   end else begin : g_cke_tie
      assign cke = 1'b1;
   end

endmodule

// File: rtl/sdram_seq_chk.sv
module sdram_seq_chk #(
   parameter int PEND_W  = 3,
   parameter int REF_MAX = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        sdram_cmd,
   input logic              acc_req,
   input logic              bus_busy,
   input logic              acc_grant,
   input logic              init_done,
   input logic [PEND_W-1:0] ref_pending,
   input logic              ref_overflow
);

   // R5
   grant_in_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !init_done |-> !acc_grant);

   // R3
   lmr_before_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sdram_cmd == 2'd3) |-> !init_done);

   // R8
   pend_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_pending <= PEND_W'(REF_MAX));

   // R8
   pend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, ref_pending} <= {1'b0, $past(ref_pending)} + 1'b1));

   // R8
   ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_overflow && init_done) |=> ref_overflow);

   // R9
   refresh_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_pending != '0) |-> !acc_grant);

   // R10
   grant_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      acc_grant |-> (acc_req && !bus_busy && init_done));

endmodule

bind sdram_seq_top sdram_seq_chk #(.PEND_W(PEND_W), .REF_MAX(REF_MAX)) u_chk (
   .clk(clk), .rst_n(rst_n), .sdram_cmd(sdram_cmd), .acc_req(acc_req),
   .bus_busy(bus_busy), .acc_grant(acc_grant), .init_done(init_done),
   .ref_pending(ref_pending), .ref_overflow(ref_overflow)
);

// File: tb/sim_sdram_seq_top.sv
module sim_sdram_seq_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sdram_mode_en = 1'b0;
   logic        clk2x_mode = 1'b1;
   logic [3:0]  cmd_wait = 4'd2;
   logic [15:0] refresh_period = 16'd0;
   logic [12:0] mode_word = 13'h123;
   logic        bus_busy = 1'b0;
   logic        acc_req = 1'b0;
   logic        acc_grant;
   logic [1:0]  sdram_cmd;
   logic [12:0] sdram_mode_word;
   logic        cke;
   logic        init_done;
   logic [2:0]  ref_pending;
   logic        ref_overflow;

   int cyc = 0;
   int nchk = 0;
   int nerr = 0;

   typedef struct {
      int    at;
      int    cmd;
      int    mr;
      string req;
   } exp_t;
   exp_t exp_q[$];

   sdram_seq_top u0 (
      .clk(clk), .rst_n(rst_n), .sdram_mode_en(sdram_mode_en),
      .clk2x_mode(clk2x_mode), .cmd_wait(cmd_wait),
      .refresh_period(refresh_period), .mode_word(mode_word),
      .bus_busy(bus_busy), .acc_req(acc_req), .acc_grant(acc_grant),
      .sdram_cmd(sdram_cmd), .sdram_mode_word(sdram_mode_word), .cke(cke),
      .init_done(init_done), .ref_pending(ref_pending),
      .ref_overflow(ref_overflow)
   );

   always #4 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input int act, input int expv);
      nchk++;
      if (act != expv) begin
         nerr++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, expv);
      end
   endtask

   task automatic push(input int at, input int cmd, input int mr, input string req);
      exp_t e;
      e.at = at; e.cmd = cmd; e.mr = mr; e.req = req;
      exp_q.push_back(e);
   endtask

   task automatic wait_cyc(input int n);
      while (cyc < n) @(negedge clk);
   endtask

   // monitor: pops the expected command whenever the design issues one
   always @(negedge clk) begin
      if (rst_n && sdram_cmd != 2'd0) begin
         if (exp_q.size() == 0) begin
            chk("R3 unexpected command", int'(sdram_cmd), 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.req, " command code"}, int'(sdram_cmd), e.cmd);
            chk({e.req, " command cycle"}, cyc, e.at);
            if (e.mr >= 0) chk({e.req, " mode word"}, int'(sdram_mode_word), e.mr);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin
      @(negedge clk);
      wait_cyc(2);
      // R1: reset state
      chk("R1 cmd", int'(sdram_cmd), 0);
      chk("R1 init_done", int'(init_done), 0);
      chk("R1 grant", int'(acc_grant), 0);
      chk("R1 pending", int'(ref_pending), 0);
      chk("R1 overflow", int'(ref_overflow), 0);
      chk("R1 cke", int'(cke), 0);
      wait_cyc(3);
      rst_n = 1'b1;

      wait_cyc(5);
      chk("R11 cke off before mode", int'(cke), 0);
      sdram_mode_en = 1'b1;
      acc_req = 1'b1;
      push(6, 1, -1, "R2");
      push(9, 2, -1, "R3");
      push(12, 2, -1, "R3");
      push(15, 3, 13'h123, "R4");
      wait_cyc(6);
      chk("R11 cke on", int'(cke), 1);
      wait_cyc(7);
      mode_word = 13'h0AA;           // R4: ignored after start
      wait_cyc(8);
      sdram_mode_en = 1'b0;          // R5: cannot interrupt
      wait_cyc(9);
      chk("R11 cke held in init", int'(cke), 1);
      wait_cyc(10);
      sdram_mode_en = 1'b1;
      wait_cyc(12);
      #1 chk("R5 no grant in init", int'(acc_grant), 0);
      wait_cyc(17);
      chk("R3 not yet done", int'(init_done), 0);
      wait_cyc(18);
      chk("R3 done", int'(init_done), 1);
      #1 chk("R10 grant when ready", int'(acc_grant), 1);
      wait_cyc(19);
      acc_req = 1'b0;

      // R7: period zero, monitor flags any refresh
      wait_cyc(50);
      chk("R7 nothing pending", int'(ref_pending), 0);
      refresh_period = 16'd20;
      push(71, 2, -1, "R6");
      push(91, 2, -1, "R6");
      wait_cyc(95);
      bus_busy = 1'b1;
      wait_cyc(120);
      clk2x_mode = 1'b0;
      wait_cyc(121);
      chk("R11 cke off", int'(cke), 0);
      clk2x_mode = 1'b1;
      wait_cyc(123);
      chk("R11 cke back", int'(cke), 1);
      wait_cyc(140);
      chk("R8 pending two", int'(ref_pending), 2);
      wait_cyc(180);
      chk("R8 pending four", int'(ref_pending), 4);
      chk("R8 no overflow yet", int'(ref_overflow), 0);
      wait_cyc(192);
      chk("R8 saturated", int'(ref_pending), 4);
      chk("R8 overflow set", int'(ref_overflow), 1);

      wait_cyc(195);
      bus_busy = 1'b0;
      acc_req = 1'b1;
      push(196, 2, -1, "R9");
      push(199, 2, -1, "R9");
      push(202, 2, -1, "R9");
      push(205, 2, -1, "R9");
      #1 chk("R9 refresh before access", int'(acc_grant), 0);
      wait_cyc(200);
      chk("R9 draining", int'(ref_pending), 2);
      wait_cyc(206);
      #1 chk("R9 gap holds grant", int'(acc_grant), 0);
      wait_cyc(207);
      #1 chk("R10 grant after drain", int'(acc_grant), 1);
      wait_cyc(208);
      bus_busy = 1'b1;
      #1 chk("R10 busy blocks grant", int'(acc_grant), 0);
      wait_cyc(209);
      bus_busy = 1'b0;
      acc_req = 1'b0;
      push(211, 2, -1, "R6");

      wait_cyc(220);
      sdram_mode_en = 1'b0;
      wait_cyc(221);
      chk("R12 leaves ready", int'(init_done), 0);
      wait_cyc(223);
      chk("R11 cke off in idle", int'(cke), 0);
      wait_cyc(225);
      sdram_mode_en = 1'b1;
      mode_word = 13'h055;
      push(226, 1, -1, "R12");
      push(229, 2, -1, "R12");
      push(232, 2, -1, "R12");
      push(235, 3, 13'h055, "R4");
      wait_cyc(226);
      chk("R12 overflow cleared", int'(ref_overflow), 0);
      chk("R12 pending cleared", int'(ref_pending), 0);
      wait_cyc(238);
      chk("R12 ready again", int'(init_done), 1);
      push(259, 2, -1, "R6");

      wait_cyc(265);
      chk("R6 all expected commands seen", exp_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

endmodule